// File: doc/BRIEF.md
# Timed Edge Playback Engine

This block replays a list of timed pin-toggle events that a host has written into a small local record buffer. Each 32-bit record holds an absolute timestamp, a pin number and a toggle-enable flag. After a rising edge on the trigger input, the engine clears its timebase to zero. It then walks the buffer from a chosen start address. Whenever the running timebase reaches the timestamp of the current record, the engine toggles the chosen output pin and moves to the next record.

The timebase has a 16-bit fast counter and an 8-bit wrap counter. A record with toggle-enable clear changes no pin. Such filler records let a sequence stretch past the fast counter's span without any pin activity. A record equal to all ones ends playback. The toggle happens on the very clock edge where the match occurs, so a pulse can be as short as one clock.

Top module: `edge_seq_engine`

## Requirements
- R1: After reset, every pin is 0 and both busy and done are 0.
- R2: If trig_in is sampled high at rising edge n after being low, busy is 1 after edge n+2. No other event starts playback.
- R3: The record format has four fields: bits 15:0 are the fast match value, bits 23:16 are the wrap match value, bits 26:24 are the pin number and bit 27 is toggle-enable. Bits 31:28 are unused. An enabled record whose 24-bit time is T, reached in order, inverts its pin at edge n+3+T.
- R4: A record with bit 27 clear inverts no pin, but it still consumes its time slot and advances to the next record.
- R5: Only one record is consumed per clock. A record whose time is already past when it is reached matches on the next edge.
- R6: A record equal to 32'hFFFFFFFF stops playback at the edge where it is reached. After that edge busy is 0 and done is 1, and done returns to 0 one cycle later.
- R7: A trigger edge that arrives while busy is 1 is ignored. No new playback follows it.
- R8: The 8-bit wrap counter counts overflows of the 16-bit counter, so record times up to 2^24-1 clocks are reachable.
- R9: Playback starts at start_addr and reads consecutive addresses. The address wraps from the last buffer entry back to entry 0.
- R10: Pins keep their levels while idle and across a new trigger. At most one pin changes per clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe for the record buffer |
| wr_addr | input | ADDR_W | Buffer address to write |
| wr_data | input | 32 | Record value to write |
| trig_in | input | 1 | Asynchronous start request; its rising edge starts playback |
| start_addr | input | ADDR_W | First record address, captured when playback starts |
| pins | output | NUM_PINS | Toggled output lines |
| busy | output | 1 | High while playback runs |
| done | output | 1 | One-cycle pulse when the end record is reached |

## Verification
Busy is due two edges after trig_in is first sampled high, because of the synchronizer and the start register. A record with time T acts three edges after that first sampling edge plus T. A record that is reached late acts one edge after the record before it. The end pulse appears at the edge where the end record is reached. The bench keeps a per-cycle model indexed by the timebase value. It raises the trigger at a falling edge, counts three rising edges, and from then on compares busy, done and every pin at each falling edge against that model. This covers each pin in a sweep, filler records, a span past the 16-bit wrap, address wrap and a retrigger while busy.

// File: rtl/esq_pkg.sv
package esq_pkg;
   localparam int REC_W    = 32;
   localparam int LO_W     = 16;
   localparam int HI_W     = 8;
   localparam int TIME_W   = LO_W + HI_W;
   localparam int SEL_W    = 3;
   localparam int EN_BIT   = 27;
   localparam logic [REC_W-1:0] END_MARK = '1;

   typedef enum logic {ST_IDLE, ST_PLAY} esq_state_t;

   function automatic logic [TIME_W-1:0] rec_time(input logic [REC_W-1:0] r);
      return r[TIME_W-1:0];
   endfunction

   function automatic logic [SEL_W-1:0] rec_pin(input logic [REC_W-1:0] r);
      return r[TIME_W+SEL_W-1:TIME_W];
   endfunction

   function automatic logic rec_en(input logic [REC_W-1:0] r);
      return r[EN_BIT];
   endfunction
endpackage

// File: rtl/esq_trig_sync.sv
module esq_trig_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic rise_o
);
   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   generate
      if (STAGES < 2) begin : g_bad
         $error("esq_trig_sync: STAGES must be at least 2");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_in};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign rise_o = chain_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/esq_rec_store.sv
module esq_rec_store #(
   parameter int ADDR_W = 6,
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              wr_en,
   input  logic [ADDR_W-1:0] wr_addr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [ADDR_W-1:0] rd_addr,
   output logic [DATA_W-1:0] rd_data
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem_q [DEPTH];

   always_ff @(posedge clk) begin
      if (wr_en) mem_q[wr_addr] <= wr_data;
   end

   assign rd_data = mem_q[rd_addr];
endmodule

// File: rtl/esq_timebase.sv
module esq_timebase #(
   parameter int LO_W = 16,
   parameter int HI_W = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 clr,
   input  logic                 en,
   output logic [HI_W+LO_W-1:0] now_o
);
   logic [LO_W-1:0] lo_q;
   logic [HI_W-1:0] hi_q;

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         lo_q <= '0;
         hi_q <= '0;
      end else if (en) begin
         lo_q <= lo_q + 1'b1;
         if (&lo_q) hi_q <= hi_q + 1'b1;
      end
   end

   assign now_o = {hi_q, lo_q};
endmodule

// File: rtl/esq_pin_bank.sv
module esq_pin_bank #(
   parameter int NUM_PINS = 8,
   parameter int SEL_W    = 3
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                fire,
   input  logic [SEL_W-1:0]    sel,
   output logic [NUM_PINS-1:0] pins_o
);
   generate
      for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
         logic lvl_q;
         always_ff @(posedge clk) begin
            if (!rst_n)                        lvl_q <= 1'b0;
            else if (fire && sel == SEL_W'(i)) lvl_q <= ~lvl_q;
         end
         assign pins_o[i] = lvl_q;
      end
   endgenerate
endmodule

// File: rtl/edge_seq_engine.sv
module edge_seq_engine
   import esq_pkg::*;
#(
   parameter int ADDR_W      = 6,
   parameter int NUM_PINS    = 8,
   parameter int SYNC_STAGES = 2
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [ADDR_W-1:0]   wr_addr,
   input  logic [31:0]         wr_data,
   input  logic                trig_in,
   input  logic [ADDR_W-1:0]   start_addr,
   output logic [NUM_PINS-1:0] pins,
   output logic                busy,
   output logic                done
);
   generate
      if (NUM_PINS < 1 || NUM_PINS > (1 << SEL_W)) begin : g_bad_pins
         $error("edge_seq_engine: NUM_PINS out of range");
      end
      if (ADDR_W < 1 || ADDR_W > 10) begin : g_bad_addr
         $error("edge_seq_engine: ADDR_W out of range");
      end
   endgenerate

   esq_state_t        state_q;
   logic [ADDR_W-1:0] ptr_q;
   logic              done_q;
   logic              trig_rise;
   logic [REC_W-1:0]  cur_rec;
   logic [TIME_W-1:0] now;
   logic              playing, at_end, due, fire;

   esq_trig_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(trig_in), .rise_o(trig_rise));

   esq_rec_store #(.ADDR_W(ADDR_W), .DATA_W(REC_W)) u_store (
      .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .rd_addr(ptr_q), .rd_data(cur_rec));

   esq_timebase #(.LO_W(LO_W), .HI_W(HI_W)) u_tb (
      .clk(clk), .rst_n(rst_n), .clr(trig_rise && !playing),
      .en(playing), .now_o(now));

   assign playing = (state_q == ST_PLAY);
   assign at_end  = (cur_rec == END_MARK);
   assign due     = playing && !at_end && (now >= rec_time(cur_rec));
   assign fire    = due && rec_en(cur_rec);

   esq_pin_bank #(.NUM_PINS(NUM_PINS), .SEL_W(SEL_W)) u_pins (
      .clk(clk), .rst_n(rst_n), .fire(fire), .sel(rec_pin(cur_rec)),
      .pins_o(pins));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         ptr_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: if (trig_rise) begin
               state_q <= ST_PLAY;
               ptr_q   <= start_addr;
            end
            default: if (at_end) begin
               state_q <= ST_IDLE;
               done_q  <= 1'b1;
            end else if (due) begin
               ptr_q <= ptr_q + 1'b1;
            end
         endcase
      end
   end

   assign busy = playing;
   assign done = done_q;
endmodule

// File: rtl/edge_seq_engine_chk.sv
module edge_seq_engine_chk #(
   parameter int NUM_PINS = 8
) (
   input logic                clk,
   input logic                rst_n,
   input logic                trig_in,
   input logic [NUM_PINS-1:0] pins,
   input logic                busy,
   input logic                done
);
   assert_clear_after_reset_R1: assert property (@(posedge clk)
      $rose(rst_n) |-> (pins == '0 && !busy && !done));

   assert_start_needs_trig_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(trig_in, 3));

   assert_one_pin_per_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(pins ^ $past(pins)));

   assert_idle_pins_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !$past(busy) |-> $stable(pins));

   assert_done_ends_run_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   assert_done_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
endmodule

bind edge_seq_engine edge_seq_engine_chk #(.NUM_PINS(NUM_PINS)) chk_i (
   .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .pins(pins),
   .busy(busy), .done(done));

// File: tb/edge_seq_engine_tb_top.sv
`timescale 1ns/1ps
module edge_seq_engine_tb_top;
   localparam int AW = 6;
   localparam int NP = 8;
   localparam int DEPTH = 1 << AW;

   logic          clk = 0, rst_n = 0, wr_en = 0, trig_in = 0;
   logic [AW-1:0] wr_addr = '0, start_addr = '0;
   logic [31:0]   wr_data = '0;
   wire  [NP-1:0] pins;
   wire           busy, done;

   int checks = 0, fails = 0;
   logic [31:0] bmem [DEPTH];
   logic [NP-1:0] exp_pins = '0;

   edge_seq_engine #(.ADDR_W(AW), .NUM_PINS(NP), .SYNC_STAGES(2)) dut_i (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
      .wr_data(wr_data), .trig_in(trig_in), .start_addr(start_addr),
      .pins(pins), .busy(busy), .done(done));

   always #10 clk = ~clk;

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic wr(input int a, input logic [31:0] d);
      @(negedge clk);
      wr_en = 1; wr_addr = AW'(a); wr_data = d; bmem[a] = d;
      @(negedge clk);
      wr_en = 0;
   endtask

   function automatic logic [31:0] rec(input bit en, input int pin, input int t);
      logic [31:0] r;
      r = {4'b0, en, 3'(pin), 24'(t)};
      return r;
   endfunction

   // Per-cycle model: loop step c is the timebase value before edge n+3+c.
   task automatic play(input int start, input bit retrig, input string req);
      int mptr;
      int c;
      bit fin;
      logic [31:0] r;
      mptr = start; c = 0; fin = 0;
      @(negedge clk);
      start_addr = AW'(start); trig_in = 1;
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(busy === 1'b1, "R2", "busy two edges after trigger", busy, 1);
      chk(pins === exp_pins, "R10", "pins kept across trigger", pins, exp_pins);
      trig_in = 0;
      while (!fin && c < 150000) begin
         if (retrig) trig_in = (c >= 3 && c < 6);
         @(posedge clk);
         @(negedge clk);
         r = bmem[mptr];
         if (r == 32'hFFFF_FFFF) begin
            fin = 1;
            chk(busy === 1'b0 && done === 1'b1, "R6", "end marker busy/done",
                {busy, done}, 2'b01);
         end else begin
            if (c >= int'(r[23:0])) begin
               if (r[27]) exp_pins[r[26:24]] = ~exp_pins[r[26:24]];
               mptr = (mptr + 1) % DEPTH;
            end
            chk(busy === 1'b1 && done === 1'b0, req, "busy while playing",
                {busy, done}, 2'b10);
         end
         chk(pins === exp_pins, req, "pin levels", pins, exp_pins);
         c++;
      end
      trig_in = 0;
      @(negedge clk);
      chk(done === 1'b0, "R6", "done lasts one cycle", done, 0);
      repeat (6) begin
         @(negedge clk);
         chk(busy === 1'b0, "R7", "no restart after run", busy, 0);
         chk(pins === exp_pins, "R10", "pins hold while idle", pins, exp_pins);
      end
   endtask

   initial begin
      #3_000_000;
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) bmem[i] = 32'hFFFF_FFFF;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      chk(pins === '0, "R1", "pins after reset", pins, 0);
      chk(busy === 1'b0 && done === 1'b0, "R1", "busy/done after reset",
          {busy, done}, 0);
      for (int i = 0; i < DEPTH; i++) wr(i, 32'hFFFF_FFFF);

      // R3 and R5: one-clock pulse, equal timestamps, retrigger while busy (R7)
      wr(0, rec(1, 0, 2));
      wr(1, rec(1, 0, 3));
      wr(2, rec(1, 7, 10));
      wr(3, rec(1, 3, 10));
      wr(4, rec(1, 3, 12));
      wr(5, 32'hFFFF_FFFF);
      play(0, 1, "R3/R5/R7");

      // R4 and R8: filler records and a span beyond the 16-bit counter
      wr(20, rec(0, 1, 5));
      wr(21, rec(1, 1, 6));
      wr(22, rec(0, 1, 32'h10000));
      wr(23, rec(1, 1, 32'h10002));
      wr(24, 32'hFFFF_FFFF);
      play(20, 0, "R4/R8");

      // R9: start near top of buffer, wrap to entry 0
      wr(0, 32'hFFFF_FFFF);
      wr(62, rec(1, 2, 1));
      wr(63, rec(1, 5, 4));
      play(62, 0, "R9");

      // R6: start directly on an end record
      play(0, 0, "R6");

      // R3: sweep every pin with varied widths
      for (int p = 0; p < NP; p++) begin
         wr(40, rec(1, p, p));
         wr(41, rec(1, p, 2 * p + 1));
         wr(42, rec(1, (p + 3) % NP, 2 * p + 1));
         wr(43, 32'hFFFF_FFFF);
         play(40, 0, "R3");
      end

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule